// File: doc/BRIEF.md
# Layer Weight Fetch Controller

This block starts the loading of a layer's weights before any per-node work of that layer begins. Software sets it up through a few small control registers. First it writes the numeric format that the weights should be fetched in. Then it writes a command register that clears itself, so the hardware sees that command as a single-cycle pulse.

On that pulse the controller starts a request to the prefetch unit and holds it until the unit accepts. The request carries a frozen copy of the format. The controller then waits for the unit's completion signal and sets a sticky done flag. Software polls that flag. When software sees it set, it writes a self-clearing acknowledge register, and the hardware drops the flag. Together these steps form a four-phase handshake built only from set-and-auto-clear registers.

A command that arrives while a fetch is running, or while done is still held, is dropped. An acknowledge that arrives while done is not held is dropped as well.

Top module: `wfetch_ctrl`

Register addresses (on `reg_waddr` and `reg_raddr`), bit 0 being the least significant bit:
- 0: format register. Bits [PREC_W-1:0] can be read and written. Reads return zeros above them.
- 1: fetch command. Writing with bit 0 = 1 sets it.
- 2: acknowledge. Writing with bit 0 = 1 sets it.
- 3: status, read-only. Bit 0 is done and bit 1 is busy.

## Requirements
- R1: After reset, `pf_req` is 0, and the status, format, command and acknowledge registers all read 0.
- R2: A write to address 0 stores `reg_wdata[PREC_W-1:0]`, and a read of address 0 returns that value with the upper bits at zero.
- R3: The command register reads 1 in the cycle after a write with bit 0 = 1, and reads 0 one cycle later with no further write.
- R4: From idle, a command write in cycle t makes `pf_req` 1 and status busy (bit 1) 1 in cycle t+2. At that point `pf_prec` equals the format register value.
- R5: `pf_req` stays 1 until a cycle in which `pf_ack` is 1, and is 0 in the cycle after that; busy stays 1.
- R6: `pf_done`, while waiting after acceptance, sets status done (bit 0) to 1 and busy to 0 in the next cycle. Done stays 1 for as long as no acknowledge pulse arrives.
- R7: An acknowledge write in cycle t while done is held makes status read 0 in cycle t+2, and a new command is accepted after that.
- R8: A command write while busy, or while done is held, has no effect: no new `pf_req`, and the status is unchanged.
- R9: `pf_prec` does not change during a fetch, even if the format register is rewritten. The new value is used by the next fetch.
- R10: While idle, `pf_done` and acknowledge writes have no effect: status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| reg_raddr | input | ADDR_W | Register read address |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| pf_req | output | 1 | Weight fetch request to the prefetch unit |
| pf_prec | output | PREC_W | Format carried with the request |
| pf_ack | input | 1 | Prefetch unit accepts the request |
| pf_done | input | 1 | Prefetch unit has finished the weight fetch |

## Verification
Suppose the handshake state machine were in the wrong state. The fault would show up at the ports within one cycle. It would appear either as a `pf_req` that starts, stops or repeats when it should not, or as status done or busy bits that disagree with the handshake phase.

A lost auto-clear would show up in the readback of the command or acknowledge register two cycles after the write. It would also show up as a second request once the fetch returns to idle.

A format copy that is not frozen would show up on `pf_prec` in the cycle after the host rewrites the format register during a fetch.

// File: rtl/wfc_pkg.sv
// Package: shared types and register addresses for the weight fetch controller.
// Assumes: addresses fit in the ADDR_W chosen at the top (at least 2 bits).
package wfc_pkg;
    typedef enum logic [1:0] {
        WF_IDLE = 2'd0,
        WF_REQ  = 2'd1,
        WF_WAIT = 2'd2,
        WF_HELD = 2'd3
    } wf_state_t;

    localparam int A_PREC = 0;
    localparam int A_CMD  = 1;
    localparam int A_ACK  = 2;
    localparam int A_STAT = 3;
    localparam int N_PULSE = 2;
endpackage

// File: rtl/wfc_autoclr.sv
// Module: single set-and-auto-clear register bit.
// Does: q is 1 for exactly the cycle after any cycle in which set is 1.
// Assumes: set is already qualified by write strobe, address and data bit.
module wfc_autoclr (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic q
);
    // Capture a set request, clear automatically on the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set;
    end
endmodule

// File: rtl/wfc_regbank.sv
// Module: host-visible registers for the weight fetch controller.
// Does: holds the format register and the self-clearing command and acknowledge bits,
//       and returns the read data combinationally.
// Assumes: PREC_W < DATA_W; a write and a read may target any address in the same cycle.
module wfc_regbank #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int PREC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              st_busy,
    input  logic              st_done,
    output logic [PREC_W-1:0] prec_q,
    output logic              cmd_pulse,
    output logic              ack_pulse
);
    import wfc_pkg::*;

    localparam int PAD_W = DATA_W - PREC_W;

    logic [N_PULSE-1:0] pulse_set;
    logic [N_PULSE-1:0] pulse_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:PREC_W];

    // Decode the write strobes for the self-clearing bits.
    assign pulse_set[0] = reg_wr && (reg_waddr == ADDR_W'(A_CMD)) && reg_wdata[0];
    assign pulse_set[1] = reg_wr && (reg_waddr == ADDR_W'(A_ACK)) && reg_wdata[0];

    genvar gi;
    generate
        for (gi = 0; gi < N_PULSE; gi++) begin : g_pulse
            wfc_autoclr u_bit (
                .clk  (clk),
                .rst_n(rst_n),
                .set  (pulse_set[gi]),
                .q    (pulse_q[gi])
            );
        end
    endgenerate

    assign cmd_pulse = pulse_q[0];
    assign ack_pulse = pulse_q[1];

    // Store the format value written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prec_q <= '0;
        else if (reg_wr && (reg_waddr == ADDR_W'(A_PREC)))
            prec_q <= reg_wdata[PREC_W-1:0];
    end

    // Select the read data by address.
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            ADDR_W'(A_PREC): reg_rdata = {{PAD_W{1'b0}}, prec_q};
            ADDR_W'(A_CMD):  reg_rdata[0] = cmd_pulse;
            ADDR_W'(A_ACK):  reg_rdata[0] = ack_pulse;
            ADDR_W'(A_STAT): reg_rdata[1:0] = {st_busy, st_done};
            default:         reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wfc_fsm.sv
// Module: handshake state machine of the weight fetch controller.
// Does: idle -> request (held until accepted) -> wait for done -> done held until acknowledged.
//       Freezes the format value when it leaves idle.
// Assumes: cmd_pulse and ack_pulse are single-cycle pulses; pf_done only matters while waiting.
module wfc_fsm #(
    parameter int PREC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_pulse,
    input  logic              ack_pulse,
    input  logic [PREC_W-1:0] prec_in,
    input  logic              pf_ack,
    input  logic              pf_done,
    output logic              pf_req,
    output logic [PREC_W-1:0] pf_prec,
    output logic              busy,
    output logic              done
);
    import wfc_pkg::*;

    wf_state_t state, state_nx;

    // Work out the next handshake phase.
    always_comb begin
        state_nx = state;
        case (state)
            WF_IDLE: if (cmd_pulse) state_nx = WF_REQ;
            WF_REQ:  if (pf_ack)    state_nx = WF_WAIT;
            WF_WAIT: if (pf_done)   state_nx = WF_HELD;
            WF_HELD: if (ack_pulse) state_nx = WF_IDLE;
            default:                state_nx = WF_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WF_IDLE;
        else        state <= state_nx;
    end

    // Freeze the format when a fetch is launched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pf_prec <= '0;
        else if (state == WF_IDLE && cmd_pulse)
            pf_prec <= prec_in;
    end

    assign pf_req = (state == WF_REQ);
    assign busy   = (state == WF_REQ) || (state == WF_WAIT);
    assign done   = (state == WF_HELD);

    // R4
    cmd_starts_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WF_IDLE && cmd_pulse) |=> pf_req);

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_req && !pf_ack) |=> pf_req);

    // R9
    prec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(state == WF_WAIT && pf_done)) |=> $stable(pf_prec));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ack_pulse) |=> done);

    // R8
    cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_pulse) |=> !pf_req);

    // R6
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pf_req && pf_done) |=> (done && !busy));
endmodule

// File: rtl/wfetch_ctrl.sv
// Module: top of the layer weight fetch controller.
// Does: links the host register bank to the fetch handshake state machine.
// Assumes: the host writes the format before issuing the command, once per layer.
module wfetch_ctrl #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int PREC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pf_req,
    output logic [PREC_W-1:0] pf_prec,
    input  logic              pf_ack,
    input  logic              pf_done
);
    logic [PREC_W-1:0] prec_q;
    logic              cmd_pulse, ack_pulse, st_busy, st_done;

    wfc_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PREC_W(PREC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata),
        .st_busy  (st_busy),
        .st_done  (st_done),
        .prec_q   (prec_q),
        .cmd_pulse(cmd_pulse),
        .ack_pulse(ack_pulse)
    );

    wfc_fsm #(.PREC_W(PREC_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_pulse(cmd_pulse),
        .ack_pulse(ack_pulse),
        .prec_in  (prec_q),
        .pf_ack   (pf_ack),
        .pf_done  (pf_done),
        .pf_req   (pf_req),
        .pf_prec  (pf_prec),
        .busy     (st_busy),
        .done     (st_done)
    );
endmodule

// File: tb/sim_wfetch_ctrl.sv
`timescale 1ns/100ps
// Bench: directed scenarios for the weight fetch controller, one task each.
module sim_wfetch_ctrl;
    localparam int DW = 32;
    localparam int AW = 2;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_waddr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_raddr = '0;
    logic [DW-1:0] reg_rdata;
    logic          pf_req;
    logic [PW-1:0] pf_prec;
    logic          pf_ack = 1'b0;
    logic          pf_done = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    wfetch_ctrl #(.DATA_W(DW), .ADDR_W(AW), .PREC_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .pf_req(pf_req), .pf_prec(pf_prec), .pf_ack(pf_ack), .pf_done(pf_done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        reg_raddr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1;
        reg_waddr = a;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1", "pf_req", DW'(pf_req), 0);
        for (int a = 0; a < 4; a++) begin
            rd(AW'(a), v);
            chk("R1", "reg readback", v, 0);
        end
    endtask

    task automatic t_prec_reg();
        logic [DW-1:0] v;
        wr(2'd0, 32'h5);
        rd(2'd0, v);
        chk("R2", "format value", v, 32'h5);
        wr(2'd0, 32'hFFFF_FFF3);
        rd(2'd0, v);
        chk("R2", "format upper bits zero", v, 32'h3);
    endtask

    task automatic t_full_fetch();
        logic [DW-1:0] v;
        wr(2'd0, 32'h6);
        wr(2'd1, 32'h1);
        rd(2'd1, v);
        chk("R3", "command reads 1 after write", v, 1);
        chk("R4", "no request yet", DW'(pf_req), 0);
        tick();
        rd(2'd1, v);
        chk("R3", "command self-cleared", v, 0);
        chk("R4", "request raised", DW'(pf_req), 1);
        chk("R4", "request format", DW'(pf_prec), 6);
        rd(2'd3, v);
        chk("R4", "busy status", v, 32'h2);
        tick(3);
        chk("R5", "request held without accept", DW'(pf_req), 1);
        pf_ack = 1'b1;
        tick();
        pf_ack = 1'b0;
        chk("R5", "request dropped after accept", DW'(pf_req), 0);
        rd(2'd3, v);
        chk("R5", "busy while waiting", v, 32'h2);
        wr(2'd1, 32'h1);
        wr(2'd0, 32'h9);
        tick(2);
        chk("R8", "command while busy ignored", DW'(pf_req), 0);
        chk("R9", "format frozen during fetch", DW'(pf_prec), 6);
        pf_done = 1'b1;
        tick();
        pf_done = 1'b0;
        rd(2'd3, v);
        chk("R6", "done set, busy clear", v, 32'h1);
        tick(5);
        rd(2'd3, v);
        chk("R6", "done sticky", v, 32'h1);
        wr(2'd1, 32'h1);
        tick(2);
        chk("R8", "command while done ignored", DW'(pf_req), 0);
        rd(2'd3, v);
        chk("R8", "status unchanged", v, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd3, v);
        chk("R7", "done still 1 one cycle after ack write", v, 32'h1);
        tick();
        rd(2'd3, v);
        chk("R7", "status cleared", v, 0);
    endtask

    task automatic t_second_fetch();
        logic [DW-1:0] v;
        wr(2'd1, 32'h1);
        tick();
        chk("R7", "new command accepted after ack", DW'(pf_req), 1);
        chk("R9", "new format used", DW'(pf_prec), 9);
        wr(2'd0, 32'h2);
        chk("R9", "format frozen during request", DW'(pf_prec), 9);
        pf_ack = 1'b1;
        tick();
        pf_ack = 1'b0;
        wr(2'd2, 32'h1);
        tick();
        rd(2'd3, v);
        chk("R10", "ack while waiting ignored", v, 32'h2);
        pf_done = 1'b1;
        tick();
        pf_done = 1'b0;
        rd(2'd3, v);
        chk("R6", "done after second fetch", v, 32'h1);
        wr(2'd2, 32'h1);
        tick();
        rd(2'd3, v);
        chk("R7", "second ack clears", v, 0);
    endtask

    task automatic t_idle_noise();
        logic [DW-1:0] v;
        pf_done = 1'b1;
        tick(2);
        pf_done = 1'b0;
        rd(2'd3, v);
        chk("R10", "done pulse in idle ignored", v, 0);
        wr(2'd2, 32'h1);
        tick();
        rd(2'd3, v);
        chk("R10", "ack in idle ignored", v, 0);
        chk("R10", "no request from noise", DW'(pf_req), 0);
        wr(2'd1, 32'h0);
        tick();
        chk("R3", "command write with bit0=0 has no effect", DW'(pf_req), 0);
        wr(2'd1, 32'h1);
        tick();
        chk("R4", "fetch with format 2", DW'(pf_prec), 2);
        pf_ack = 1'b1;
        tick();
        pf_ack = 1'b0;
        pf_done = 1'b1;
        tick();
        pf_done = 1'b0;
        wr(2'd2, 32'h1);
        tick();
        rd(2'd3, v);
        chk("R7", "back to idle", v, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_prec_reg();
        t_full_fetch();
        t_second_fetch();
        t_idle_noise();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule